// File: doc/BRIEF.md
# Center-Aligned PWM Timer

This block is a timer whose counter climbs from zero to a programmed top value and then falls back to zero, over and over. Several compare channels watch the count. Because the counter passes through every count twice per cycle, each compare value produces two match events per period. The first comes while counting down and the second while counting up. A two-bit mode field per channel picks what those two events do to the channel pin. Pulses come out symmetric about the count-zero instant, so the pulse centres of all channels coincide.

Software writes the top value, the compare values, the mode fields and the interrupt enables through a simple address/data write port. The top value and the compare values pass through shadow copies. These shadow copies move into the working registers only while the count is zero, so a period never mixes old and new settings. Channel match flags and a turnaround flag are sticky and are cleared by strobes. Each channel interrupt is its flag gated by that channel's enable.

Top module: `ca_pwm_timer`

## Requirements
- R1: The count starts at 0 counting up, steps by one per clock up to the working top value, turns around and steps down to 0, then climbs again. With a working top value of 0 the count stays at 0.
- R2: For a top value M>0 the count repeats every 2*M cycles. On an active-high channel with compare value C (0<C<M), `pwm_o` is high for 2*C cycles per period, and it is high in the cycle where `cnt_o` reads 0.
- R3: When the count equals a channel's working compare value, that channel's flag reads 1 from the next cycle on. The channel's `ch_irq_o` bit equals its flag ANDed with its enable bit.
- R4: With mode value 2 (active high), the pin goes high the cycle after a match seen while counting down. It goes low the cycle after a match seen while counting up.
- R5: With mode value 1 or 3 (active low), the pin goes low the cycle after a down-counting match. It goes high the cycle after an up-counting match.
- R6: With mode value 0, `pwm_oe_o` is 0 and `pwm_o` is 0 for that channel, while its flag still sets on a match.
- R7: With a nonzero mode, a working compare value of 0 holds the pin at its inactive level. A working compare value at or above the working top value holds it at its active level.
- R8: `ovf_o` reads 1 from the cycle after the count sits at a nonzero top value while counting up.
- R9: A flag stays set until its clear strobe. A strobe in a cycle with no new set event clears it. A strobe in the same cycle as a set event leaves it set.
- R10: Writes to the top value and the compare values land in shadow registers. Each shadow register is copied to the working register at the clock edge that ends a cycle in which the count is 0.
- R11: Write addresses are as follows. Address 0 is the top value. Address 1 holds the interrupt enables, with bit n for channel n. Address 2+2n is the compare value of channel n. Address 3+2n is the mode of channel n, taken from data bits [1:0]. Mode and enable writes act from the next cycle.
- R12: While reset is held and right after it, the count, all flags, `ovf_o`, `ch_irq_o`, `pwm_o` and `pwm_oe_o` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | CNT_W | Write data |
| ch_clr_i | input | NUM_CH | Per-channel flag clear strobes |
| ovf_clr_i | input | 1 | Turnaround flag clear strobe |
| cnt_o | output | CNT_W | Current count |
| ovf_o | output | 1 | Sticky turnaround flag |
| ch_flag_o | output | NUM_CH | Sticky channel match flags |
| ch_irq_o | output | NUM_CH | Channel interrupts |
| pwm_o | output | NUM_CH | Channel pins |
| pwm_oe_o | output | NUM_CH | Channel pin drive enables |

## Verification
The bench builds the block with four channels and an 8-bit count, which gives an address field of four bits. The narrow count makes the largest top value, 255, cheap to run. A full 510-cycle period with a compare value at that maximum fits in the run, so the 100% duty corner and the return to top value 0 are exercised. Four channels are enough to run active-high, active-low, zero-compare and full-compare channels side by side. The run then switches one channel to mode 0 while the others keep going.

// File: rtl/ca_pwm_pkg.sv
package ca_pwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    localparam logic [1:0] MODE_OFF = 2'b00;

endpackage

// File: rtl/ca_updown_counter.sv
module ca_updown_counter
    import ca_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             top_wr_i,
    input  logic [CNT_W-1:0] top_data_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output cnt_dir_e         dir_o,
    output logic [CNT_W-1:0] top_o,
    output logic             at_zero_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
        logic [CNT_W-1:0] top_act;
        logic [CNT_W-1:0] top_shd;
        logic             ovf;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       at_zero;
    logic       turn;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        turn    = (st_q.dir == DIR_UP) && !at_zero && (st_q.cnt == st_q.top_act);

        if (top_wr_i) begin
            st_d.top_shd = top_data_i;
        end

        if (at_zero) begin
            st_d.top_act = st_q.top_shd;
            st_d.dir     = DIR_UP;
            if (st_q.top_shd == '0) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = CNT_W'(1);
            end
        end else if (st_q.dir == DIR_UP) begin
            if (st_q.cnt >= st_q.top_act) begin
                st_d.cnt = st_q.cnt - 1'b1;
                st_d.dir = DIR_DOWN;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        st_d.ovf = turn | (st_q.ovf & ~ovf_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, dir: DIR_UP, top_act: '0, top_shd: '0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign dir_o     = st_q.dir;
    assign top_o     = st_q.top_act;
    assign at_zero_o = at_zero;
    assign ovf_o     = st_q.ovf;

    // R1: the count never exceeds the working top value
    a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.top_act);

    // R1: away from zero the count moves by exactly one
    a_r1_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt != '0) |=> ((st_q.cnt == $past(st_q.cnt) + 1'b1) ||
                              (st_q.cnt == $past(st_q.cnt) - 1'b1)));

    // R8: the turnaround flag only rises after the count sat at the top going up
    a_r8_ovf_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.ovf) |-> $past((st_q.dir == DIR_UP) && (st_q.cnt == st_q.top_act)));

    // R10: the working top value changes only after a zero count
    a_r10_top_loads_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.top_act) |-> ($past(st_q.cnt) == '0));

endmodule

// File: rtl/ca_compare_channel.sv
module ca_compare_channel
    import ca_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  cnt_dir_e         dir_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             load_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_data_i,
    input  logic             mode_wr_i,
    input  logic [1:0]       mode_data_i,
    input  logic             irq_en_i,
    input  logic             clr_i,
    output logic             flag_o,
    output logic             irq_o,
    output logic             pwm_o,
    output logic             oe_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp_act;
        logic [CNT_W-1:0] cmp_shd;
        logic [1:0]       mode;
        logic             flag;
        logic             active;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        st_d = st_q;
        hit  = (cnt_i == st_q.cmp_act);

        if (cmp_wr_i) begin
            st_d.cmp_shd = cmp_data_i;
        end
        if (mode_wr_i) begin
            st_d.mode = mode_data_i;
        end
        if (load_i) begin
            st_d.cmp_act = st_q.cmp_shd;
        end

        if (st_q.mode != MODE_OFF) begin
            if (st_q.cmp_act == '0) begin
                st_d.active = 1'b0;
            end else if (st_q.cmp_act >= top_i) begin
                st_d.active = 1'b1;
            end else if (hit && (dir_i == DIR_DOWN)) begin
                st_d.active = 1'b1;
            end else if (hit && (dir_i == DIR_UP)) begin
                st_d.active = 1'b0;
            end
        end

        st_d.flag = hit | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;
    assign oe_o   = (st_q.mode != MODE_OFF);
    assign pwm_o  = oe_o & (st_q.active ^ st_q.mode[0]);

    // R3: a match is always followed by a set flag
    a_r3_flag_follows_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> st_q.flag);

    // R9: without a clear strobe a set flag stays set
    a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flag && !clr_i) |=> st_q.flag);

    // R7: zero compare value keeps the channel inactive
    a_r7_zero_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.mode != MODE_OFF) && (st_q.cmp_act == '0)) |=> !st_q.active);

    // R4: the active state only begins at a down-counting match or a full-duty setting
    a_r4_active_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.active) |-> $past((hit && (dir_i == DIR_DOWN)) || (st_q.cmp_act >= top_i)));

endmodule

// File: rtl/ca_pwm_timer.sv
module ca_pwm_timer
    import ca_pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned ADDR_W = $clog2(2 * NUM_CH + 2)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [NUM_CH-1:0] ch_clr_i,
    input  logic              ovf_clr_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_o,
    output logic [NUM_CH-1:0] ch_flag_o,
    output logic [NUM_CH-1:0] ch_irq_o,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [NUM_CH-1:0] pwm_oe_o
);

    localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_IEN = ADDR_W'(1);

    typedef struct packed {
        logic [NUM_CH-1:0] irq_en;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             top_wr;
    logic [CNT_W-1:0] cnt;
    cnt_dir_e         dir;
    logic [CNT_W-1:0] top_act;
    logic             at_zero;

    always_comb begin
        st_d   = st_q;
        top_wr = wr_en_i && (wr_addr_i == ADDR_TOP);
        if (wr_en_i && (wr_addr_i == ADDR_IEN)) begin
            st_d.irq_en = wr_data_i[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ca_updown_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .top_wr_i   (top_wr),
        .top_data_i (wr_data_i),
        .ovf_clr_i  (ovf_clr_i),
        .cnt_o      (cnt),
        .dir_o      (dir),
        .top_o      (top_act),
        .at_zero_o  (at_zero),
        .ovf_o      (ovf_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic cmp_wr;
        logic mode_wr;

        always_comb begin
            cmp_wr  = wr_en_i && (wr_addr_i == ADDR_W'(2 + 2 * g));
            mode_wr = wr_en_i && (wr_addr_i == ADDR_W'(3 + 2 * g));
        end

        ca_compare_channel #(
            .CNT_W (CNT_W)
        ) i_channel (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .cnt_i       (cnt),
            .dir_i       (dir),
            .top_i       (top_act),
            .load_i      (at_zero),
            .cmp_wr_i    (cmp_wr),
            .cmp_data_i  (wr_data_i),
            .mode_wr_i   (mode_wr),
            .mode_data_i (wr_data_i[1:0]),
            .irq_en_i    (st_q.irq_en[g]),
            .clr_i       (ch_clr_i[g]),
            .flag_o      (ch_flag_o[g]),
            .irq_o       (ch_irq_o[g]),
            .pwm_o       (pwm_o[g]),
            .oe_o        (pwm_oe_o[g])
        );
    end

    assign cnt_o = cnt;

    // R3: an interrupt never shows without its flag
    a_r3_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ch_irq_o & ~ch_flag_o) == '0);

    // R6: an undriven pin reads 0
    a_r6_undriven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwm_o & ~pwm_oe_o) == '0);

endmodule

// File: tb/test_ca_pwm_timer.sv
module test_ca_pwm_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int CW   = 8;
    localparam int AW   = $clog2(2 * NCH + 2);

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [CW-1:0] wr_data_i = '0;
    logic [NCH-1:0] ch_clr_i = '0;
    logic          ovf_clr_i = 1'b0;
    logic [CW-1:0] cnt_o;
    logic          ovf_o;
    logic [NCH-1:0] ch_flag_o, ch_irq_o, pwm_o, pwm_oe_o;

    ca_pwm_timer #(.NUM_CH(NCH), .CNT_W(CW)) i_ca_pwm_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ch_clr_i(ch_clr_i), .ovf_clr_i(ovf_clr_i),
        .cnt_o(cnt_o), .ovf_o(ovf_o), .ch_flag_o(ch_flag_o), .ch_irq_o(ch_irq_o),
        .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
    );

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    typedef struct {
        int cnt;
        int ovf;
        int flag;
        int irq;
        int pwm;
        int oe;
    } exp_t;

    exp_t q_exp[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference model state
    int m_cnt = 0, m_top = 0, m_top_shd = 0;
    bit m_down = 0, m_ovf = 0;
    int m_cmp[NCH], m_cmp_shd[NCH];
    int m_mode[NCH];
    bit m_ie[NCH], m_flag[NCH], m_act[NCH];

    task automatic check(string tag, int got, int expv);
        n_chk++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, expv, $time);
        end
    endtask

    // driver-side model: at each edge predict the outputs and queue them
    always @(posedge clk_i) begin
        if (rst_ni) begin
            bit   zero;
            bit   turn;
            exp_t e;
            zero = (m_cnt == 0);
            turn = !m_down && (m_cnt != 0) && (m_cnt == m_top);
            for (int c = 0; c < NCH; c++) begin
                bit hit;
                hit = (m_cnt == m_cmp[c]);
                if (m_mode[c] != 0) begin
                    if (m_cmp[c] == 0) m_act[c] = 0;
                    else if (m_cmp[c] >= m_top) m_act[c] = 1;
                    else if (hit && m_down) m_act[c] = 1;
                    else if (hit && !m_down) m_act[c] = 0;
                end
                m_flag[c] = hit | (m_flag[c] & !ch_clr_i[c]);
                if (zero) m_cmp[c] = m_cmp_shd[c];
                if (wr_en_i && wr_addr_i == AW'(2 + 2 * c)) m_cmp_shd[c] = int'(wr_data_i);
                if (wr_en_i && wr_addr_i == AW'(3 + 2 * c)) m_mode[c] = int'(wr_data_i[1:0]);
                if (wr_en_i && wr_addr_i == AW'(1)) m_ie[c] = wr_data_i[c];
            end
            m_ovf = turn | (m_ovf & !ovf_clr_i);
            if (zero) begin
                m_top  = m_top_shd;
                m_down = 0;
                m_cnt  = (m_top_shd == 0) ? 0 : 1;
            end else if (!m_down) begin
                if (m_cnt >= m_top) begin
                    m_cnt  = m_cnt - 1;
                    m_down = 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
            if (wr_en_i && wr_addr_i == AW'(0)) m_top_shd = int'(wr_data_i);
            e.cnt = m_cnt; e.ovf = m_ovf;
            e.flag = 0; e.irq = 0; e.pwm = 0; e.oe = 0;
            for (int c = 0; c < NCH; c++) begin
                bit oe;
                oe = (m_mode[c] != 0);
                e.flag |= int'(m_flag[c]) << c;
                e.irq  |= int'(m_flag[c] & m_ie[c]) << c;
                e.oe   |= int'(oe) << c;
                e.pwm  |= int'(oe & (m_act[c] ^ m_mode[c][0])) << c;
            end
            q_exp.push_back(e);
        end
    end

    // monitor: pop and compare a quarter period after each edge
    always @(posedge clk_i) begin
        #(CLK_PERIOD / 4);
        if (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            check("R1 R10 count", int'(cnt_o), e.cnt);
            check("R8 turnaround flag", int'(ovf_o), e.ovf);
            check("R3 R9 channel flags", int'(ch_flag_o), e.flag);
            check("R3 R11 interrupts", int'(ch_irq_o), e.irq);
            check("R4 R5 R7 pins", int'(pwm_o), e.pwm);
            check("R6 drive enables", int'(pwm_oe_o), e.oe);
        end
    end

    task automatic write_reg(int addr, int data);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_addr_i = AW'(addr);
        wr_data_i = CW'(data);
        @(negedge clk_i);
        wr_en_i   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic sample();
        @(posedge clk_i);
        #(CLK_PERIOD / 4);
    endtask

    // count, over n samples, cycles with pin ch high and cycles with count at tv / at 0
    task automatic measure(int n, int ch, int tv, output int hi, output int at_top,
                           output int at_bot, output int hi_at_bot);
        hi = 0; at_top = 0; at_bot = 0; hi_at_bot = 0;
        for (int i = 0; i < n; i++) begin
            sample();
            if (pwm_o[ch]) hi++;
            if (int'(cnt_o) == tv) at_top++;
            if (cnt_o == '0) begin
                at_bot++;
                if (pwm_o[ch]) hi_at_bot++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, tp, bt, hb;
        for (int c = 0; c < NCH; c++) begin
            m_cmp[c] = 0; m_cmp_shd[c] = 0; m_mode[c] = 0;
            m_ie[c] = 0; m_flag[c] = 0; m_act[c] = 0;
        end
        // R12: state while in reset
        idle(3);
        check("R12 count in reset", int'(cnt_o), 0);
        check("R12 flags in reset", int'(ch_flag_o) + int'(ovf_o) + int'(ch_irq_o), 0);
        check("R12 pins in reset", int'(pwm_o) + int'(pwm_oe_o), 0);
        rst_ni = 1'b1;
        sample();
        check("R12 count after reset", int'(cnt_o), 0);
        check("R12 pins after reset", int'(pwm_o), 0);

        // R11: configure via address map
        write_reg(2, 5);  write_reg(3, 2);   // ch0 active high, compare 5
        write_reg(4, 3);  write_reg(5, 1);   // ch1 active low, compare 3
        write_reg(6, 0);  write_reg(7, 2);   // ch2 compare 0
        write_reg(8, 8);  write_reg(9, 3);   // ch3 compare at top, active low
        write_reg(1, 5);                     // enables for ch0 and ch2
        write_reg(0, 8);
        idle(40);

        // R2: period 16, active-high width 10, centred on zero
        measure(16, 0, 8, hi, tp, bt, hb);
        check("R2 top visits per period", tp, 1);
        check("R2 zero visits per period", bt, 1);
        check("R2 high width ch0", hi, 10);
        check("R2 high at centre ch0", hb, 1);
        // R5: active-low width 6 -> 10 high samples
        measure(16, 1, 8, hi, tp, bt, hb);
        check("R5 high samples ch1", hi, 10);
        // R7: zero compare stays inactive (low); full compare active-low stays low
        measure(16, 2, 8, hi, tp, bt, hb);
        check("R7 zero compare ch2", hi, 0);
        measure(16, 3, 8, hi, tp, bt, hb);
        check("R7 full compare ch3", hi, 0);

        // R9: clears, then clear held while matches keep coming
        @(negedge clk_i); ch_clr_i = '1; ovf_clr_i = 1'b1;
        @(negedge clk_i); ch_clr_i = '0; ovf_clr_i = 1'b0;
        @(negedge clk_i); ch_clr_i = 4'b0001;
        idle(20);
        @(negedge clk_i); ch_clr_i = '0;
        idle(10);

        // R10: rewrite top and compare mid-period
        write_reg(0, 5);
        write_reg(2, 2);
        idle(30);
        measure(10, 0, 5, hi, tp, bt, hb);
        check("R10 new top visits", tp, 1);
        check("R10 new high width ch0", hi, 4);
        measure(10, 1, 5, hi, tp, bt, hb);
        check("R5 high samples ch1 new top", hi, 4);

        // R6: mode 0 on ch1
        write_reg(5, 0);
        idle(3);
        check("R6 drive enable ch1 off", int'(pwm_oe_o[1]), 0);
        @(negedge clk_i); ch_clr_i = 4'b0010;
        @(negedge clk_i); ch_clr_i = '0;
        idle(12);
        sample();
        check("R6 flag still sets ch1", int'(ch_flag_o[1]), 1);

        // R7: largest top, compare at maximum gives full duty
        write_reg(0, 255);
        write_reg(2, 255);
        idle(30);
        measure(20, 0, 255, hi, tp, bt, hb);
        check("R7 full duty ch0", hi, 20);
        idle(520);

        // R1: top 0 parks the count at zero
        write_reg(0, 0);
        idle(520);
        measure(10, 0, 0, hi, tp, bt, hb);
        check("R1 parked at zero", bt, 10);

        // R1: top 1 edge
        write_reg(0, 1);
        idle(20);
        measure(4, 0, 1, hi, tp, bt, hb);
        check("R1 top one visits", tp, 2);

        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule